// File: doc/BRIEF.md
# Edge Timestamp Capture Unit

This block records the moment at which an external signal changes level. It watches one of two capture pins, brings the chosen pin into the system clock domain, can pass it through a digital agreement filter that suppresses short glitches, and then looks for an edge of a selectable polarity. On each qualifying edge it copies the present value of a free-running timer count into a capture register and raises a capture flag. Software reads the register and clears the flag by writing a one to the clear input.

The agreement filter runs on the system clock, independent of any timer prescaling. When it is switched on, a pin change reaches the capture register exactly four system clock cycles later than without it. Because the source mux sits in front of the synchronizer, changing the source selection can itself look like an edge and produce a capture. Software is expected to clear the flag after such a change. When the capture register is being used as the timer's TOP value, capturing is switched off entirely.

Top module: `capture_unit`

## Requirements
- R1: After reset the capture register reads 0 and the flag is 0.
- R2: With the filter off and `rise_sel`=1, a rising edge on the selected pin loads the capture register with the timer count present at the clock edge two cycles after the pin is first sampled. It also sets the flag. A falling edge in this mode does nothing.
- R3: With `rise_sel`=0, a falling edge triggers the capture and a rising edge does nothing.
- R4: With `filt_en`=1, the capture happens exactly four cycles later than with the filter off, so the count captured is larger by four.
- R5: With `filt_en`=1, a pin pulse lasting three cycles or less is ignored. A pulse of four cycles is captured.
- R6: A one on `flag_clr` clears the flag on the next clock edge when no capture happens in that cycle.
- R7: A new capture overwrites the register even when the flag is still set.
- R8: If a capture and `flag_clr` fall in the same cycle, the flag stays 1 and the register takes the new count.
- R9: `src_sel`=0 selects `pin_a` and `src_sel`=1 selects `pin_b`. Edges on the pin that is not selected are ignored.
- R10: If the two pins differ in level, changing `src_sel` produces a capture when the new level makes a qualifying edge.
- R11: While `cap_off`=1, no edge loads the register or sets the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tcnt | input | 16 | Free-running timer count |
| pin_a | input | 1 | Capture pin, source 0 |
| pin_b | input | 1 | Capture pin, source 1 |
| src_sel | input | 1 | Source select (0 = pin_a, 1 = pin_b) |
| rise_sel | input | 1 | Edge polarity (1 = rising, 0 = falling) |
| filt_en | input | 1 | Enables the four-sample agreement filter |
| cap_off | input | 1 | Disables capture (capture register is TOP) |
| flag_clr | input | 1 | Write-one-to-clear for the flag |
| cap_val | output | 16 | Capture register |
| cap_flag | output | 1 | Capture flag |

## Verification
The hardest situation to reach is a capture and a flag clear landing on the same clock edge. The bench gets there by counting the synchronizer latency and raising `flag_clr` on the negative edge just before the capture edge, at a point where the flag is already set from an earlier capture. The filter's edge cases are reached with pin pulses of exactly three and exactly four cycles. The spurious capture from a source change is set up by parking the two pins at different levels before moving `src_sel`.

// File: rtl/capture_pkg.sv
package capture_pkg;
   localparam int unsigned CAP_TW      = 16;
   localparam int unsigned CAP_SYNC    = 2;
   localparam int unsigned CAP_SAMPLES = 4;

   typedef enum logic {
      EDGE_FALL = 1'b0,
      EDGE_RISE = 1'b1
   } edge_pol_e;
endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cap_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain[0] <= din;
         for (int i = 1; i < int'(STAGES); i++) begin
            chain[i] <= chain[i-1];
         end
      end
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/cap_filter.sv
module cap_filter #(
   parameter int unsigned SAMPLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   if (SAMPLES < 1) begin : g_bad_samples
      $error("cap_filter: SAMPLES must be at least 1");
   end

   if (SAMPLES == 1) begin : g_pass
      assign dout = din;
   end else begin : g_vote
      localparam int unsigned HW = SAMPLES - 1;
      logic [HW-1:0] hist;
      logic          level_q;
      logic          all_hi;
      logic          all_lo;

      assign all_hi = (&hist) & din;
      assign all_lo = ~((|hist) | din);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hist    <= '0;
            level_q <= 1'b0;
         end else begin
            hist[0] <= din;
            for (int i = 1; i < int'(HW); i++) begin
               hist[i] <= hist[i-1];
            end
            if (all_hi) begin
               level_q <= 1'b1;
            end else if (all_lo) begin
               level_q <= 1'b0;
            end
         end
      end

      assign dout = level_q;
   end
endmodule

// File: rtl/cap_edge.sv
module cap_edge
   import capture_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      level,
   input  edge_pol_e pol,
   output logic      hit
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
      end else begin
         prev_q <= level;
      end
   end

   always_comb begin
      unique case (pol)
         EDGE_RISE: hit = level & ~prev_q;
         default:   hit = ~level & prev_q;
      endcase
   end
endmodule

// File: rtl/capture_unit.sv
module capture_unit
   import capture_pkg::*;
#(
   parameter int unsigned TW          = CAP_TW,
   parameter int unsigned SYNC_STAGES = CAP_SYNC,
   parameter int unsigned SAMPLES     = CAP_SAMPLES
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [TW-1:0] tcnt,
   input  logic          pin_a,
   input  logic          pin_b,
   input  logic          src_sel,
   input  logic          rise_sel,
   input  logic          filt_en,
   input  logic          cap_off,
   input  logic          flag_clr,
   output logic [TW-1:0] cap_val,
   output logic          cap_flag
);
   if (TW < 2) begin : g_bad_tw
      $error("capture_unit: TW must be at least 2");
   end

   logic      pin_mux;
   logic      pin_sync;
   logic      pin_filt;
   logic      level;
   logic      edge_hit;
   logic      cap_event;
   edge_pol_e pol;

   assign pin_mux = src_sel ? pin_b : pin_a;
   assign pol     = rise_sel ? EDGE_RISE : EDGE_FALL;

   cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (pin_mux),
      .dout  (pin_sync)
   );

   cap_filter #(.SAMPLES(SAMPLES)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (pin_sync),
      .dout  (pin_filt)
   );

   assign level = filt_en ? pin_filt : pin_sync;

   cap_edge u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .level (level),
      .pol   (pol),
      .hit   (edge_hit)
   );

   assign cap_event = edge_hit & ~cap_off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_val  <= '0;
         cap_flag <= 1'b0;
      end else begin
         if (cap_event) begin
            cap_val  <= tcnt;
            cap_flag <= 1'b1;
         end else if (flag_clr) begin
            cap_flag <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/capture_unit_chk.sv
module capture_unit_chk #(
   parameter int unsigned TW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic [TW-1:0] tcnt,
   input logic          cap_off,
   input logic          flag_clr,
   input logic          edge_hit,
   input logic          cap_event,
   input logic [TW-1:0] cap_val,
   input logic          cap_flag
);
   // R7: every capture loads the count seen at that edge
   a_r7_load_count: assert property (@(posedge clk) disable iff (!rst_n)
      cap_event |=> cap_val == $past(tcnt));

   // R8: capture wins over a simultaneous clear
   a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      cap_event |=> cap_flag);

   // R6: a clear without a capture drops the flag
   a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !cap_event) |=> !cap_flag);

   // R2: without a capture the register holds
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_event |=> $stable(cap_val));

   // R11: disabled capture never raises a cleared flag
   a_r11_off: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_off && edge_hit && !cap_flag) |=> !cap_flag);
endmodule

bind capture_unit capture_unit_chk #(.TW(TW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tcnt      (tcnt),
   .cap_off   (cap_off),
   .flag_clr  (flag_clr),
   .edge_hit  (edge_hit),
   .cap_event (cap_event),
   .cap_val   (cap_val),
   .cap_flag  (cap_flag)
);

// File: tb/capture_unit_test.sv
module capture_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] tcnt = '0;
   logic        pin_a = 1'b0, pin_b = 1'b0;
   logic        src_sel = 1'b0, rise_sel = 1'b1, filt_en = 1'b0;
   logic        cap_off = 1'b0, flag_clr = 1'b0;
   logic [15:0] cap_val;
   logic        cap_flag;

   int checks = 0;
   int bad = 0;
   logic [15:0] expq[$];
   logic [15:0] last_val = '0;

   always #10 clk = ~clk;

   always @(posedge clk) begin
      if (rst_n) tcnt <= tcnt + 16'd1;
   end

   capture_unit uut (
      .clk(clk), .rst_n(rst_n), .tcnt(tcnt), .pin_a(pin_a), .pin_b(pin_b),
      .src_sel(src_sel), .rise_sel(rise_sel), .filt_en(filt_en),
      .cap_off(cap_off), .flag_clr(flag_clr), .cap_val(cap_val),
      .cap_flag(cap_flag)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // driver: expected capture = count now + pipeline latency
   task automatic push(input int lat);
      expq.push_back(tcnt + 16'(lat));
   endtask

   task automatic clr();
      flag_clr = 1'b1;
      cyc(1);
      flag_clr = 1'b0;
   endtask

   // monitor / scoreboard
   initial begin
      @(posedge rst_n);
      forever begin
         @(negedge clk);
         if (cap_val !== last_val) begin
            if (expq.size() == 0) begin
               checks++; bad++;
               $display("FAIL R9/R11 unexpected capture: actual=%0h expected=none", cap_val);
            end else begin
               check("R2/R4/R7 captured count", cap_val, expq.pop_front());
            end
            check("R2 flag on capture", {15'd0, cap_flag}, 16'd1);
            last_val = cap_val;
         end
      end
   end

   initial begin
      #2_000_000;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      cyc(3);
      check("R1 reset value", cap_val, 16'd0);
      check("R1 reset flag", {15'd0, cap_flag}, 16'd0);
      rst_n = 1'b1;
      cyc(5);

      // R2 rising edge, filter off
      pin_a = 1'b1; push(2);
      cyc(8);
      check("R2 flag set", {15'd0, cap_flag}, 16'd1);
      clr();
      check("R6 flag cleared", {15'd0, cap_flag}, 16'd0);
      pin_a = 1'b0;            // falling in rising mode: ignored
      cyc(8);
      check("R2 falling ignored", {15'd0, cap_flag}, 16'd0);

      // R3 falling mode
      rise_sel = 1'b0;
      pin_a = 1'b1; cyc(8);
      check("R3 rising ignored", {15'd0, cap_flag}, 16'd0);
      pin_a = 1'b0; push(2); cyc(8);
      check("R3 falling captured", {15'd0, cap_flag}, 16'd1);
      clr();
      rise_sel = 1'b1;
      cyc(4);

      // R4 filter latency, R5 glitch rejection
      filt_en = 1'b1;
      cyc(8);
      pin_a = 1'b1; push(6); cyc(10);
      pin_a = 1'b0; cyc(10);
      clr();
      pin_a = 1'b1; cyc(3); pin_a = 1'b0; cyc(10);
      check("R5 three-cycle pulse ignored", {15'd0, cap_flag}, 16'd0);
      pin_a = 1'b1; push(6); cyc(4); pin_a = 1'b0; cyc(10);
      check("R5 four-cycle pulse captured", {15'd0, cap_flag}, 16'd1);
      filt_en = 1'b0;
      cyc(6);

      // R7 overwrite while flag set
      pin_a = 1'b1; push(2); cyc(6);
      pin_a = 1'b0; cyc(6);
      pin_a = 1'b1; push(2); cyc(6);
      check("R7 flag still set", {15'd0, cap_flag}, 16'd1);
      pin_a = 1'b0; cyc(6);

      // R8 clear in the capture cycle
      pin_a = 1'b1; push(2);
      cyc(2);
      flag_clr = 1'b1;
      cyc(1);
      flag_clr = 1'b0;
      check("R8 flag kept", {15'd0, cap_flag}, 16'd1);
      pin_a = 1'b0; cyc(6);
      clr();

      // R10 source change makes an edge
      pin_b = 1'b1; cyc(8);
      check("R9 unselected pin_b ignored", {15'd0, cap_flag}, 16'd0);
      src_sel = 1'b1; push(2); cyc(8);
      check("R10 source switch capture", {15'd0, cap_flag}, 16'd1);
      clr();

      // R9 pin_a ignored while pin_b selected
      pin_a = 1'b1; cyc(6); pin_a = 1'b0; cyc(6);
      check("R9 unselected pin_a ignored", {15'd0, cap_flag}, 16'd0);
      pin_b = 1'b0; cyc(6);
      pin_b = 1'b1; push(2); cyc(8);
      check("R9 pin_b captured", {15'd0, cap_flag}, 16'd1);
      clr();
      pin_b = 1'b0; cyc(6);

      // R11 capture disabled
      cap_off = 1'b1;
      pin_b = 1'b1; cyc(6); pin_b = 1'b0; cyc(6); pin_b = 1'b1; cyc(6);
      check("R11 flag stays clear", {15'd0, cap_flag}, 16'd0);
      check("R11 register unchanged", cap_val, last_val);
      cap_off = 1'b0;
      cyc(6);

      checks++;
      if (expq.size() != 0) begin
         bad++;
         $display("FAIL R2 missing captures: actual=%0d expected=0", expq.size());
      end
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule